// File: doc/BRIEF.md
# Byte FIFO Controller for External Static RAM

This block turns a 2048-byte external static RAM into a circular byte FIFO. A producer on the acquisition side offers one byte per push strobe. A host drains the FIFO one byte at a time through a read data register. The RAM has a single port, so one address bus carries either the write pointer or the read pointer, depending on the memory cycle in progress. A chip select, a write enable and a shared bidirectional data bus complete the RAM side.

The controller keeps one staging byte for pushes and fills the read data register ahead of the host. It does this by prefetching whenever the register is vacant and the FIFO holds unread data. The host sees three conditions in a status byte: the FIFO is empty, the read data register holds no byte, and the FIFO is full. After reset the block stays inert and ignores pushes until the host issues the initialise command.

The sequencer has four states:
- ST_HALT: idle after reset. It waits for the initialise command and leaves to ST_IDLE when that command arrives.
- ST_IDLE: no memory cycle is in progress.
- ST_WRITE: one RAM write of the staged byte. The sequencer stays in ST_WRITE while further pushes arrive.
- ST_READ: one RAM read into the read data register.

From ST_IDLE, ST_WRITE or ST_READ, the next state is chosen in this order:
1. ST_WRITE if a staged byte will be pending.
2. Otherwise ST_READ if the register will be vacant and unread bytes remain.
3. Otherwise ST_IDLE.

The initialise command forces ST_IDLE from any state.

Top module: `sfc_top`

## Requirements
- R1: After rst_n is released, the status byte reads 0x06 and mem_sel stays low. Pushes have no effect until the initialise command has been written.
- R2: A host write to register address 6 is the initialise command. It clears both pointers, the staged byte and the data-present flag, and it enables acquisition, so the status reads 0x06 afterwards. Host writes to any other address change nothing.
- R3: Pushed bytes are written to the RAM at consecutive addresses, modulo 2048. The first write after the initialise command goes to address 0.
- R4: When the FIFO holds an unread byte and the read data register is vacant, the block loads the oldest byte into the register without any host action.
- R5: A host read of register address 1 returns the read data register. If a byte was present, the read consumes it and the next oldest byte follows. If no byte was present, the read consumes nothing.
- R6: A host read of register address 0 returns the status byte. Bit 2 is 1 when the FIFO holds no byte. Bit 1 is 1 when the read data register is vacant. Bit 0 is 1 when 2048 bytes are held. Bits 7 to 3 are 0. Reads of addresses other than 0 and 1 return 0.
- R7: Once 2048 bytes are held, status bit 0 is set and further pushes are dropped without changing the stored contents. Consuming one byte clears bit 0.
- R8: Pushes on consecutive cycles are all accepted, because a write always wins the memory cycle over a prefetch read. Bytes come out in the order they were pushed.
- R9: mem_we is high only while mem_sel is high. The block drives mem_dq only during a write cycle, and both strobes are low while the block is idle.
- R10: An initialise command issued while data is held discards that data. Bytes pushed afterwards are returned first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Push strobe from acquisition, one byte per cycle |
| push_data | input | 8 | Byte to push |
| host_cs | input | 1 | Host chip select, active high |
| host_rd | input | 1 | Host read strobe, active high, one cycle per access |
| host_wr | input | 1 | Host write strobe, active high |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data (not stored) |
| host_rdata | output | 8 | Host read data |
| mem_addr | output | 11 | RAM address |
| mem_dq | inout | 8 | RAM data bus |
| mem_sel | output | 1 | RAM select |
| mem_we | output | 1 | RAM write enable |

## Verification
The FIFO is exercised with four kinds of stimulus:
- Short bursts of pushes on back-to-back cycles. These show whether a push is lost while a prefetch competes for the memory cycle.
- A full fill of 2048 bytes followed by one extra push. This separates correct drop-on-full from overwriting the oldest data.
- Reads of an empty data register. These show whether the read pointer advances when it must not.
- Seeded random mixes of bursts and drains that wrap the pointers many times. Comparing every popped byte against a queue model exposes ordering, wrap and off-by-one faults, and status reads at settled points check the empty, data-present and full flags.

Pushes before and after the initialise command separate the armed and unarmed states.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_WRITE = 2'd2,
        ST_READ  = 2'd3
    } seq_state_t;

    localparam logic [2:0] REG_STATUS = 3'd0;
    localparam logic [2:0] REG_DATA   = 3'd1;
    localparam logic [2:0] REG_INIT   = 3'd6;
endpackage

// File: rtl/sfc_host_dec.sv
module sfc_host_dec
    import sfc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          host_cs,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [2:0]    host_addr,
    input  logic [DW-1:0] status,
    input  logic [DW-1:0] read_reg,
    output logic          pop_req,
    output logic          init_cmd,
    output logic [DW-1:0] rdata
);
    logic rd_sel;
    assign rd_sel   = host_cs && host_rd;
    assign pop_req  = rd_sel && (host_addr == REG_DATA);
    assign init_cmd = host_cs && host_wr && (host_addr == REG_INIT);

    always_comb begin
        rdata = '0;
        if (rd_sel) begin
            if (host_addr == REG_STATUS)    rdata = status;
            else if (host_addr == REG_DATA) rdata = read_reg;
        end
    end
endmodule

// File: rtl/sfc_ptrs.sv
module sfc_ptrs #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_inc,
    input  logic          rd_inc,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   used,
    output logic          unread_next
);
    logic [AW:0] wr_q, rd_q, wr_d, rd_d;

    assign wr_d        = wr_q + {{AW{1'b0}}, wr_inc};
    assign rd_d        = rd_q + {{AW{1'b0}}, rd_inc};
    assign unread_next = (wr_d != rd_d);
    assign used        = wr_q - rd_q;
    assign wr_addr     = wr_q[AW-1:0];
    assign rd_addr     = rd_q[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else if (clr) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            wr_q <= wr_d;
            rd_q <= rd_d;
        end
    end
endmodule

// File: rtl/sfc_mem_seq.sv
module sfc_mem_seq
    import sfc_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_cmd,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    input  logic [AW:0]   used,
    input  logic          unread_next,
    input  logic [DW-1:0] dq_in,
    output logic          wr_inc,
    output logic          rd_inc,
    output logic          armed,
    output logic          data_present,
    output logic [DW-1:0] read_reg,
    output logic [AW:0]   level,
    output logic          mem_sel,
    output logic          mem_we,
    output logic          dq_oe,
    output logic [DW-1:0] dq_out,
    output logic          use_wr_addr
);
    localparam logic [AW:0] DEPTH = {1'b1, {AW{1'b0}}};

    seq_state_t    state_q, state_d;
    logic          pend_q, pend_d, dp_q, dp_d;
    logic [DW-1:0] stage_q, rreg_q;
    logic          accept, draining, fetch_d;

    assign armed        = (state_q != ST_HALT);
    assign draining     = (state_q == ST_WRITE);
    assign level        = used + {{AW{1'b0}}, pend_q};
    assign accept       = armed && push_valid && !init_cmd && (level < DEPTH);
    assign pend_d       = (pend_q && !draining) || accept;
    assign rd_inc       = pop_req && dp_q;
    assign dp_d         = (dp_q && !rd_inc) || (state_q == ST_READ);
    assign fetch_d      = !dp_d && unread_next;
    assign wr_inc       = draining;
    assign data_present = dp_q;
    assign read_reg     = rreg_q;
    assign dq_out       = stage_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (init_cmd) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_HALT:  state_d = ST_HALT;
                ST_IDLE,
                ST_WRITE,
                ST_READ:  state_d = pend_d ? ST_WRITE : (fetch_d ? ST_READ : ST_IDLE);
                default:  state_d = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // memory strobes per state
    always_comb begin
        mem_sel     = 1'b0;
        mem_we      = 1'b0;
        dq_oe       = 1'b0;
        use_wr_addr = 1'b0;
        unique case (state_q)
            ST_WRITE: begin
                mem_sel     = 1'b1;
                mem_we      = 1'b1;
                dq_oe       = 1'b1;
                use_wr_addr = 1'b1;
            end
            ST_READ:  mem_sel = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            dp_q    <= 1'b0;
            stage_q <= '0;
            rreg_q  <= '0;
        end else if (init_cmd) begin
            pend_q <= 1'b0;
            dp_q   <= 1'b0;
        end else begin
            pend_q <= pend_d;
            dp_q   <= dp_d;
            if (accept)              stage_q <= push_data;
            if (state_q == ST_READ)  rreg_q  <= dq_in;
        end
    end
endmodule

// File: rtl/sfc_top.sv
module sfc_top
    import sfc_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    input  logic          host_cs,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [2:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic [AW-1:0] mem_addr,
    inout  wire  [DW-1:0] mem_dq,
    output logic          mem_sel,
    output logic          mem_we
);
    localparam logic [AW:0] DEPTH = {1'b1, {AW{1'b0}}};

    logic          pop_req, init_cmd, wr_inc, rd_inc, unread_next;
    logic          armed_w, dp_w, dq_oe, use_wr_addr;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [AW:0]   used, level;
    logic [DW-1:0] read_reg, dq_out, status_w;
    logic          wdata_unused;

    assign wdata_unused = ^host_wdata;
    assign status_w = {{(DW-3){1'b0}}, (level == '0), !dp_w, (level == DEPTH)};
    assign mem_addr = use_wr_addr ? wr_addr : rd_addr;
    assign mem_dq   = dq_oe ? dq_out : {DW{1'bz}};

    sfc_host_dec #(.DW(DW)) u_dec (
        .host_cs  (host_cs),
        .host_rd  (host_rd),
        .host_wr  (host_wr),
        .host_addr(host_addr),
        .status   (status_w),
        .read_reg (read_reg),
        .pop_req  (pop_req),
        .init_cmd (init_cmd),
        .rdata    (host_rdata)
    );

    sfc_ptrs #(.AW(AW)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (init_cmd),
        .wr_inc     (wr_inc),
        .rd_inc     (rd_inc),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .used       (used),
        .unread_next(unread_next)
    );

    sfc_mem_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_cmd    (init_cmd),
        .push_valid  (push_valid),
        .push_data   (push_data),
        .pop_req     (pop_req),
        .used        (used),
        .unread_next (unread_next),
        .dq_in       (mem_dq),
        .wr_inc      (wr_inc),
        .rd_inc      (rd_inc),
        .armed       (armed_w),
        .data_present(dp_w),
        .read_reg    (read_reg),
        .level       (level),
        .mem_sel     (mem_sel),
        .mem_we      (mem_we),
        .dq_oe       (dq_oe),
        .dq_out      (dq_out),
        .use_wr_addr (use_wr_addr)
    );
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_cs,
    input logic          host_wr,
    input logic [2:0]    host_addr,
    input logic          mem_sel,
    input logic          mem_we,
    input logic [DW-1:0] status,
    input logic          armed
);
    localparam logic [DW-1:0] ST_CLEAR = {{(DW-3){1'b0}}, 3'b110};

    assert_we_needs_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_sel);

    assert_halt_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !mem_sel);

    assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_wr && host_addr == 3'd6) |=> (status == ST_CLEAR));

    assert_empty_nodata_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> status[1]);

    assert_not_full_and_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[2] && status[0]));
endmodule

bind sfc_top sfc_checker #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_cs  (host_cs),
    .host_wr  (host_wr),
    .host_addr(host_addr),
    .mem_sel  (mem_sel),
    .mem_we   (mem_we),
    .status   (status_w),
    .armed    (armed_w)
);

// File: tb/sfc_top_bench.sv
module sfc_top_bench;
    localparam int DEPTH = 2048;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, push_valid, host_cs, host_rd, host_wr;
    logic [7:0]  push_data, host_wdata;
    logic [2:0]  host_addr;
    logic [7:0]  host_rdata;
    logic [10:0] mem_addr;
    wire  [7:0]  mem_dq;
    logic        mem_sel, mem_we;

    logic [7:0]  ram [DEPTH];
    assign mem_dq = (mem_sel && !mem_we) ? ram[mem_addr] : 8'hzz;

    int   checks = 0, fails = 0, writes = 0;
    bit   armed_m = 0, first_seen = 0;
    logic [10:0] first_addr = '0;
    logic [7:0]  q[$];

    sfc_top u_sfc_top (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_addr(mem_addr),
        .mem_dq(mem_dq), .mem_sel(mem_sel), .mem_we(mem_we)
    );

    always @(posedge clk) begin
        if (mem_sel && mem_we) begin
            ram[mem_addr] <= mem_dq;
            writes <= writes + 1;
            if (!first_seen) begin
                first_seen <= 1'b1;
                first_addr <= mem_addr;
            end
        end
    end

    function automatic logic [7:0] exp_status(int n);
        return {5'b0, n == 0, n == 0, n == DEPTH};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic host_read(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_cs = 1; host_rd = 1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_cs = 0; host_rd = 0;
    endtask

    task automatic host_write(logic [2:0] a);
        @(negedge clk);
        host_cs = 1; host_wr = 1; host_addr = a; host_wdata = 8'($urandom);
        @(negedge clk);
        host_cs = 0; host_wr = 0;
        if (a == 3'd6) begin
            armed_m = 1;
            q.delete();
            first_seen = 0;
        end
    endtask

    task automatic push_burst(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            push_valid = 1; push_data = 8'($urandom);
            if (armed_m && q.size() < DEPTH) q.push_back(push_data);
        end
        @(negedge clk);
        push_valid = 0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic check_status(string tag);
        logic [7:0] d;
        host_read(3'd0, d);
        check(tag, d, exp_status(q.size()));
    endtask

    task automatic pop_check(string tag);
        logic [7:0] d;
        host_read(3'd1, d);
        if (q.size() > 0) check(tag, d, q.pop_front());
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int w0;
        void'($urandom(32'h5FC0_1234));
        rst_n = 0; push_valid = 0; push_data = 0; host_cs = 0; host_rd = 0;
        host_wr = 0; host_addr = 0; host_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state and pushes ignored before the initialise command
        check_status("R1 reset status");
        check("R1 mem_sel low", {31'b0, mem_sel}, 0);
        push_burst(3);
        settle();
        check_status("R1 pushes ignored");
        check("R1 no ram write", writes, 0);
        // R2: other write addresses do nothing
        host_write(3'd3);
        push_burst(2);
        settle();
        check_status("R2 non-init write");
        check("R2 still no write", writes, 0);
        host_write(3'd6);
        check_status("R2 after init");
        // R3/R4/R8: back-to-back pushes, prefetch, order
        push_burst(3);
        settle();
        check("R3 first address", first_addr, 0);
        check_status("R4 data prefetched");
        check("R9 idle strobes", {30'b0, mem_sel, mem_we}, 0);
        for (int i = 0; i < 3; i++) pop_check("R8 burst order");
        check_status("R6 empty after drain");
        // R5: empty read does not consume
        host_read(3'd1, d);
        repeat (3) @(negedge clk);
        check_status("R5 empty read");
        push_burst(1);
        settle();
        pop_check("R5 pointer unchanged");
        // R6: unused read address
        host_read(3'd5, d);
        check("R6 other read zero", d, 0);
        // R7: fill and overflow
        w0 = writes;
        push_burst(DEPTH + 1);
        settle();
        check("R7 extra push dropped", writes - w0, DEPTH);
        check_status("R7 full");
        pop_check("R7 oldest kept");
        check_status("R7 full clears");
        while (q.size() > 0) pop_check("R7 drain order");
        check_status("R7 empty after drain");
        // random mix, pointers wrap
        for (int it = 0; it < 300; it++) begin
            push_burst($urandom_range(0, 20));
            settle();
            check_status("R6 random status");
            for (int k = $urandom_range(0, 20); k > 0; k--) pop_check("R5 random order");
        end
        // R10: initialise discards held data
        push_burst(5);
        settle();
        host_write(3'd6);
        check_status("R10 cleared");
        push_burst(1);
        settle();
        pop_check("R10 fresh byte first");
        check_status("R10 empty");
        finish_run();
    end
endmodule